// File: doc/BRIEF.md
# Four-lane SPI master shift engine

This block is a serial master that runs one transfer at a time on a single clock line, a single data output and a single active-high select. While it shifts out a fixed number of low-order bits from a transmit word, it samples four separate serial inputs in parallel. Each input fills its own receive word. A requester raises `go_i` and can hold it. The engine answers with `done_o` and keeps `done_o` high until `go_i` is released, so a stalled bus master can use `done_o` directly as its acknowledge.

The serial clock rate comes from a three-bit code. Code 0 toggles the serial clock on every system clock. Each higher code doubles the half-period. Data follows SPI mode 0: the clock idles low, the engine drives new output data after each falling edge, and it samples the inputs on each rising edge. The default transfer is 24 bits. In that case the outgoing bits are word bits 23 down to 0, which carry a read flag, a byte count, padding, a register address and a data byte, in that order. The last byte returned by each slave lands in bits 7:0 of its receive word.

Top module: `spi_quad_master`

## Requirements
- R1: While `rst_ni` is low (asynchronous), `cs_o`, `sclk_o`, `mosi_o` and `done_o` are 0, `bit_idx_o` is 0 and all receive words are 0.
- R2: `go_i` sampled high while idle starts a transfer, and `cs_o` is 1 after that clock edge. Dropping and raising `go_i` during a transfer, or holding it high after completion, starts nothing new.
- R3: The serial clock half-period is 2^`div_sel_i` system cycles. `done_o` rises exactly 2·XFER_LEN·2^`div_sel_i` clock edges after the edge that accepted `go_i`, and exactly XFER_LEN rising serial clock edges occur.
- R4: `mosi_o` presents `tx_word_i[XFER_LEN-1]` first and bit 0 last. It changes only together with a falling serial clock edge while selected, and it is 0 whenever `cs_o` is 0.
- R5: On each rising serial clock edge every lane shifts its `miso_i` bit into bit 0 of its own receive word. Lane k occupies `rx_words_o[32k+31:32k]`.
- R6: Receive words clear when a transfer starts, so after completion bits XFER_LEN and above are 0 and the last byte received is in bits 7:0.
- R7: `done_o` stays 1 while `go_i` is held. It falls on the first edge that sees `go_i` low, and `cs_o` is 0 whenever `done_o` is 1.
- R8: `cs_o` is 1 only during a transfer, and `sclk_o` is 0 whenever `cs_o` is 0.
- R9: `bit_idx_o` equals the number of falling serial clock edges completed so far in the transfer. It stays below XFER_LEN and changes only with a falling edge.
- R10: Bits of `tx_word_i` at positions XFER_LEN and above have no effect on `mosi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Transfer request, may be held |
| div_sel_i | input | 3 | Serial clock rate code |
| tx_word_i | input | 32 | Transmit word, low XFER_LEN bits sent |
| miso_i | input | 4 | Serial inputs, one per lane |
| done_o | output | 1 | Transfer complete, held while go_i high |
| cs_o | output | 1 | Active-high select |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data output |
| bit_idx_o | output | 5 | Current bit number |
| rx_words_o | output | 128 | Four receive words, lane 0 lowest |

## Verification
A divider counter that wraps at the wrong value changes the spacing of serial edges. That shows up in the very first half-period and in the total cycles to `done_o`. A bit counter or shift register that is off by one puts a wrong `mosi_o` bit at some rising edge and misplaces the returned byte. A wrong state encoding leaves `cs_o` or `done_o` high past the edge where it should fall, and the ports show this within one cycle. All eight rate codes are swept so that each divider width is exercised at least once.

// File: rtl/spi_quad_pkg.sv
package spi_quad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   half_len;
  logic [CNT_W:0]   half_m1_full;
  logic [CNT_W-1:0] half_m1;

  assign half_len     = {{CNT_W{1'b0}}, 1'b1} << sel_i;
  assign half_m1_full = half_len - {{CNT_W{1'b0}}, 1'b1};
  assign half_m1      = half_m1_full[CNT_W-1:0];
  assign tick_o       = en_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_tx_shreg.sv
module spi_tx_shreg #(
  parameter int XFER_LEN = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [XFER_LEN-1:0] data_i,
  output logic                msb_o
);
  logic [XFER_LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= data_i;
    else if (shift_i)  sh_q <= {sh_q[XFER_LEN-2:0], 1'b0};
  end

  assign msb_o = sh_q[XFER_LEN-1];
endmodule

// File: rtl/spi_rx_lane.sv
module spi_rx_lane #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic [WORD_W-1:0] rx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_o <= '0;
    else if (clr_i)     rx_o <= '0;
    else if (sample_i)  rx_o <= {rx_o[WORD_W-2:0], miso_i};
  end
endmodule

// File: rtl/spi_quad_master.sv
module spi_quad_master
  import spi_quad_pkg::*;
#(
  parameter int XFER_LEN  = 24,
  parameter int WORD_W    = 32,
  parameter int NUM_LANES = 4,
  parameter int DIV_W     = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          go_i,
  input  logic [DIV_W-1:0]              div_sel_i,
  input  logic [WORD_W-1:0]             tx_word_i,
  input  logic [NUM_LANES-1:0]          miso_i,
  output logic                          done_o,
  output logic                          cs_o,
  output logic                          sclk_o,
  output logic                          mosi_o,
  output logic [$clog2(XFER_LEN)-1:0]   bit_idx_o,
  output logic [NUM_LANES*WORD_W-1:0]   rx_words_o
);
  localparam int IDX_W = $clog2(XFER_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

  xfer_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic sclk_q;
  logic start, tick, rise, fall, last, tx_msb;

  assign start = (state_q == ST_IDLE) && go_i;
  assign rise  = tick && !sclk_q;
  assign fall  = tick && sclk_q;
  assign last  = fall && (idx_q == LAST_IDX);

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .clr_i  (start),
    .sel_i  (div_sel_i),
    .tick_o (tick)
  );

  spi_tx_shreg #(.XFER_LEN(XFER_LEN)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .shift_i (fall && !last),
    .data_i  (tx_word_i[XFER_LEN-1:0]),
    .msb_o   (tx_msb)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    spi_rx_lane #(.WORD_W(WORD_W)) u_rx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start),
      .sample_i (rise),
      .miso_i   (miso_i[k]),
      .rx_o     (rx_words_o[k*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_i)  state_d = ST_SHIFT;
      ST_SHIFT: if (last)  state_d = ST_DONE;
      ST_DONE:  if (!go_i) state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start || last)  sclk_q <= 1'b0;
      else if (tick)      sclk_q <= ~sclk_q;
      if (start || last)  idx_q <= '0;
      else if (fall)      idx_q <= idx_q + 1'b1;
    end
  end

  assign cs_o      = (state_q == ST_SHIFT);
  assign done_o    = (state_q == ST_DONE);
  assign sclk_o    = sclk_q;
  assign mosi_o    = cs_o && tx_msb;
  assign bit_idx_o = idx_q;
endmodule

// File: rtl/spi_quad_master_chk.sv
module spi_quad_master_chk #(
  parameter int XFER_LEN = 24
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        go_i,
  input logic                        done_o,
  input logic                        cs_o,
  input logic                        sclk_o,
  input logic                        mosi_o,
  input logic [$clog2(XFER_LEN)-1:0] bit_idx_o
);
  // R8
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o);
  // R4
  mosi_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !mosi_o);
  // R4
  mosi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mosi_o) && cs_o && $past(cs_o)) |-> $fell(sclk_o));
  // R7
  done_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && go_i) |=> done_o);
  // R7
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !go_i) |=> (!done_o && !cs_o));
  // R2
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> $past(go_i));
  // R9
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_o < XFER_LEN);
  // R9
  idx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(bit_idx_o) && cs_o && $past(cs_o)) |-> $fell(sclk_o));
endmodule

bind spi_quad_master spi_quad_master_chk #(.XFER_LEN(XFER_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .go_i      (go_i),
  .done_o    (done_o),
  .cs_o      (cs_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .bit_idx_o (bit_idx_o)
);

// File: tb/spi_quad_master_tb.sv
module spi_quad_master_tb;
  localparam int XL = 24;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic go_i = 1'b0;
  logic [2:0] div_sel_i = '0;
  logic [W-1:0] tx_word_i = '0;
  logic [3:0] miso_i = '0;
  logic done_o, cs_o, sclk_o, mosi_o;
  logic [4:0] bit_idx_o;
  logic [4*W-1:0] rx_words_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] pats [4];

  always #5 clk = ~clk;

  spi_quad_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .go_i(go_i), .div_sel_i(div_sel_i),
    .tx_word_i(tx_word_i), .miso_i(miso_i), .done_o(done_o), .cs_o(cs_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .bit_idx_o(bit_idx_o), .rx_words_o(rx_words_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_miso(input int i);
    for (int k = 0; k < 4; k++) miso_i[k] = pats[k][i];
  endtask

  task automatic idle_chk(input string req);
    chk(!cs_o && !sclk_o && !mosi_o && !done_o, req, "idle outputs",
        {28'b0, cs_o, sclk_o, mosi_o, done_o}, '0);
    chk(bit_idx_o == 0, req, "bit index idle", W'(bit_idx_o), '0);
  endtask

  task automatic xfer(input logic [2:0] sel, input logic [W-1:0] tx, input bit glitch);
    int cyc, rises, falls, mos_err, idx_err, cs_err, lim;
    logic prev_s, prev_m;
    lim = 2 * XL * (1 << sel) + 1;
    @(negedge clk);
    div_sel_i = sel; tx_word_i = tx; set_miso(XL - 1); go_i = 1'b1;
    cyc = 0; rises = 0; falls = 0; mos_err = 0; idx_err = 0; cs_err = 0;
    prev_s = 1'b0; prev_m = tx[XL-1];
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (glitch && cyc == 5) go_i = 1'b0;
      if (glitch && cyc == 6) go_i = 1'b1;
      if (done_o || cyc > lim + 8) break;
      if (!cs_o) cs_err++;
      if (sclk_o && !prev_s) begin
        if (mosi_o !== tx[XL-1-rises] || mosi_o !== prev_m) mos_err++;
        if (bit_idx_o != rises) idx_err++;
        rises++;
      end else if (!sclk_o && prev_s) begin
        falls++;
        if (falls < XL) set_miso(XL - 1 - falls);
      end else if (mosi_o !== prev_m) begin
        mos_err++;
      end
      prev_s = sclk_o; prev_m = mosi_o;
    end
    // R3: edge count from acceptance to completion
    chk(cyc == lim, "R3", "cycles to done", W'(cyc), W'(lim));
    chk(rises == XL, "R3", "rising sclk count", W'(rises), W'(XL));
    // R4 / R10: serial order, change timing, upper tx bits ignored
    chk(mos_err == 0, "R4", "mosi bit errors", W'(mos_err), '0);
    chk(idx_err == 0, "R9", "bit index errors", W'(idx_err), '0);
    chk(cs_err == 0 && !cs_o, "R8", "select during transfer", W'(cs_err), '0);
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] exp_rx;
      exp_rx = pats[k] & ((W'(1) << XL) - 1);
      // R5 R6: per-lane capture, last byte in bits 7:0, upper bits cleared
      chk(rx_words_o[k*W +: W] == exp_rx, "R5", "lane receive word", rx_words_o[k*W +: W], exp_rx);
    end
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      // R7 R2: done held, no restart while go held
      chk(done_o && !cs_o, "R7", "done held", {30'b0, done_o, cs_o}, 32'h2);
    end
    go_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!done_o && !cs_o, "R7", "done released", {30'b0, done_o, cs_o}, '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) pats[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    idle_chk("R1");
    chk(rx_words_o == '0, "R1", "rx reset", rx_words_o[W-1:0], '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    idle_chk("R1");

    for (int s = 0; s < 8; s++) begin
      pats[0] = 32'hC3A5_0F96 ^ (32'h0101_0101 * s);
      pats[1] = ~pats[0];
      pats[2] = 32'hAAAA_AAAA;
      pats[3] = 32'h1234_5678 + 32'h0011_2233 * s;
      xfer(3'(s), 32'hFF80_0F5A ^ (32'h0003_0507 * s), 1'b0);
      pats[2] = 32'h5555_5555;
      pats[3] = 32'hFFFF_FFFF;
      xfer(3'(s), 32'h00FF_FFFF ^ (32'h0010_2040 * s), 1'b0);
    end
    // R2: go dropped and raised mid-transfer must not restart
    pats[0] = 32'h0000_00FF; pats[1] = 32'h00FF_0000;
    pats[2] = 32'h0081_8181; pats[3] = 32'h0000_0001;
    xfer(3'd1, 32'hA5C3_3C5A, 1'b1);
    xfer(3'd0, 32'h0000_0001, 1'b1);
    // R10: identical low bits, different high bits
    xfer(3'd0, 32'h0012_3456, 1'b0);
    xfer(3'd0, 32'hFF12_3456, 1'b0);

    // R1: asynchronous reset mid-transfer
    @(negedge clk);
    div_sel_i = 3'd2; tx_word_i = 32'h00FF_FFFF; go_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_o, "R2", "select active before reset", {31'b0, cs_o}, 32'h1);
    rst_ni = 1'b0; go_i = 1'b0;
    #1;
    idle_chk("R1");
    chk(rx_words_o == '0, "R1", "rx cleared by reset", rx_words_o[W-1:0], '0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    idle_chk("R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule